// File: doc/BRIEF.md
# Core Boundary Register with Safe Mode

This block is the ring of test cells that surrounds an embedded core. One bank of cells sits on the core's input paths, between the system side and the core. A second bank sits on the core's output paths, between the core and the system side. A 2-bit mode code from the instruction decoder selects how the ring behaves:

- **Functional:** the ring is transparent.
- **Inward test:** the core is driven from the ring.
- **Outward test:** the system side is driven from the ring.
- **Safe:** both the core inputs and the system-side outputs are forced to fixed values.

In serial access the two banks form one scan segment. The segment runs from `scan_in` through every input-path cell and then every output-path cell to `scan_out`. It is clocked by the test clock with capture, shift and update strobes.

Every cell holds two flops. A shift flop forms the scan path. An update flop loads from the shift flop only on the update strobe, so driven values stay still while a new pattern is shifted in. The safe values are per-cell parameter vectors whose default is all zeros. The cell counts are parameters.

Top module: `core_boundary_ring`

## Requirements
- R1: While `test_rst_n` is low, all shift and update flops are cleared and the ring acts in functional mode whatever the `mode` code: `core_in` = `sys_in`, `sys_out` = `core_out`, `scan_out` = 0. After reset a full scan-out returns all zeros.
- R2: Mode 2'b00 (functional): `core_in` equals `sys_in` and `sys_out` equals `core_out`, combinationally.
- R3: Mode 2'b01 (inward test): bit i of `core_in` equals the update flop of input-path cell i. `sys_out` still equals `core_out`.
- R4: Mode 2'b10 (outward test): bit j of `sys_out` equals the update flop of output-path cell j. `core_in` still equals `sys_in`.
- R5: Mode 2'b11 (safe): `core_in` equals parameter `SAFE_IN` and `sys_out` equals parameter `SAFE_OUT`, regardless of update flop contents.
- R6: On each rising test-clock edge with `shift_en` high and `cap_en` low, data moves one cell toward `scan_out`. The chain order is `scan_in` → input cell 0 … input cell N_IN-1 → output cell 0 … output cell N_OUT-1 → `scan_out`. `scan_out` is the shift flop of the last output cell.
- R7: On a rising edge with `cap_en` high, input-path shift flops load `sys_in` and output-path shift flops load `core_out`, in every mode. Capture takes priority over a simultaneous shift.
- R8: Update flops load the shift flops only on a rising edge with `upd_en` high. Shifting without update leaves every driven value unchanged.
- R9: In safe mode the shift and update path stays operable: a pattern shifted and updated in safe mode appears on `core_in` once the mode changes to inward test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock; all flops update on its rising edge |
| test_rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 functional, 01 inward test, 10 outward test, 11 safe |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| scan_in | input | 1 | Serial data into input cell 0 |
| scan_out | output | 1 | Serial data from the last output cell |
| sys_in | input | N_IN | System-side functional inputs |
| core_in | output | N_IN | Inputs delivered to the core |
| core_out | input | N_OUT | Outputs produced by the core |
| sys_out | output | N_OUT | System-side functional outputs |

## Verification
A corrupted shift flop surfaces on `scan_out` within at most N_IN+N_OUT shift edges, at the chain position where it sits. A corrupted update flop is invisible in functional and safe modes. It shows up on `core_in` or `sys_out` as soon as the matching test mode is selected, with no clock edge needed. For that reason the checks always switch into the test mode after each update, and compare full scanned-out words against computed chain positions.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    typedef enum logic [1:0] {
        RING_FUNC    = 2'b00,
        RING_INWARD  = 2'b01,
        RING_OUTWARD = 2'b10,
        RING_SAFE    = 2'b11
    } ring_mode_e;

    typedef struct packed {
        logic in_from_upd;
        logic out_from_upd;
        logic force_safe;
    } ring_ctl_t;
endpackage

// File: rtl/cbr_mode_dec.sv
module cbr_mode_dec
    import cbr_pkg::*;
(
    input  logic       rst_n,
    input  logic [1:0] mode,
    output ring_ctl_t  ctl
);
    ring_mode_e eff_mode;

    always_comb begin
        eff_mode = rst_n ? ring_mode_e'(mode) : RING_FUNC;
        ctl = '0;
        case (eff_mode)
            RING_INWARD:  ctl.in_from_upd  = 1'b1;
            RING_OUTWARD: ctl.out_from_upd = 1'b1;
            RING_SAFE:    ctl.force_safe   = 1'b1;
            default:      ctl = '0;
        endcase
    end
endmodule

// File: rtl/cbr_cell_bank.sv
module cbr_cell_bank #(
    parameter int               WIDTH    = 4,
    parameter logic [WIDTH-1:0] SAFE_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             shift_en,
    input  logic             upd_en,
    input  logic             si,
    output logic             so,
    input  logic [WIDTH-1:0] func_in,
    input  logic             use_upd,
    input  logic             use_safe,
    output logic [WIDTH-1:0] drive
);
    typedef struct packed {
        logic [WIDTH-1:0] sh;
        logic [WIDTH-1:0] upd;
    } bank_t;

    bank_t          st_d, st_q;
    logic [WIDTH:0] sh_ext;

    always_comb begin
        st_d   = st_q;
        sh_ext = {st_q.sh, si};
        if (cap_en) begin
            st_d.sh = func_in;
        end else if (shift_en) begin
            st_d.sh = sh_ext[WIDTH-1:0];
        end
        if (upd_en) begin
            st_d.upd = st_q.sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        assign drive[g] = use_safe ? SAFE_VAL[g]
                        : (use_upd ? st_q.upd[g] : func_in[g]);
    end

    assign so = st_q.sh[WIDTH-1];

    // R6: first cell takes scan data on a shift edge
    p_shift_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !cap_en) |=> (st_q.sh[0] == $past(si)));

    // R7: capture loads the functional-side value
    p_capture_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (st_q.sh == $past(func_in)));

    // R8: update flops hold without the update strobe
    p_upd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(st_q.upd));

    // R8: update flops take the shift flops on the strobe
    p_upd_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (st_q.upd == $past(st_q.sh)));
endmodule

// File: rtl/core_boundary_ring.sv
module core_boundary_ring
    import cbr_pkg::*;
#(
    parameter int               N_IN     = 4,
    parameter int               N_OUT    = 3,
    parameter logic [N_IN-1:0]  SAFE_IN  = '0,
    parameter logic [N_OUT-1:0] SAFE_OUT = '0
) (
    input  logic             test_clk,
    input  logic             test_rst_n,
    input  logic [1:0]       mode,
    input  logic             cap_en,
    input  logic             shift_en,
    input  logic             upd_en,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic [N_IN-1:0]  sys_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] sys_out
);
    ring_ctl_t ctl;
    logic      mid_link;

    cbr_mode_dec u_dec (
        .rst_n (test_rst_n),
        .mode  (mode),
        .ctl   (ctl)
    );

    cbr_cell_bank #(.WIDTH(N_IN), .SAFE_VAL(SAFE_IN)) u_in_bank (
        .clk      (test_clk),
        .rst_n    (test_rst_n),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .upd_en   (upd_en),
        .si       (scan_in),
        .so       (mid_link),
        .func_in  (sys_in),
        .use_upd  (ctl.in_from_upd),
        .use_safe (ctl.force_safe),
        .drive    (core_in)
    );

    cbr_cell_bank #(.WIDTH(N_OUT), .SAFE_VAL(SAFE_OUT)) u_out_bank (
        .clk      (test_clk),
        .rst_n    (test_rst_n),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .upd_en   (upd_en),
        .si       (mid_link),
        .so       (scan_out),
        .func_in  (core_out),
        .use_upd  (ctl.out_from_upd),
        .use_safe (ctl.force_safe),
        .drive    (sys_out)
    );

    // R5: safe code forces both driven sides
    p_safe_force_r5: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        (mode == 2'b11) |-> (core_in == SAFE_IN && sys_out == SAFE_OUT));

    // R2: functional code keeps both paths transparent
    p_func_pass_r2: assert property (@(posedge test_clk) disable iff (!test_rst_n)
        (mode == 2'b00) |-> (core_in == sys_in && sys_out == core_out));
endmodule

// File: tb/sim_core_boundary_ring.sv
module sim_core_boundary_ring;
    localparam int NI = 4;
    localparam int NO = 3;
    localparam int CH = NI + NO;
    localparam logic [NI-1:0] S_IN  = 4'b1010;
    localparam logic [NO-1:0] S_OUT = 3'b011;

    logic          test_clk = 1'b0;
    logic          test_rst_n = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, scan_in = 1'b0;
    logic          scan_out;
    logic [NI-1:0] sys_in = '0, core_in;
    logic [NO-1:0] core_out = '0, sys_out;

    int checks = 0;
    int errors = 0;

    always #4 test_clk = ~test_clk;

    core_boundary_ring #(.N_IN(NI), .N_OUT(NO), .SAFE_IN(S_IN), .SAFE_OUT(S_OUT)) u0 (
        .test_clk, .test_rst_n, .mode, .cap_en, .shift_en, .upd_en,
        .scan_in, .scan_out, .sys_in, .core_in, .core_out, .sys_out
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Shift CH bits; load[p] lands at chain position p; old[p] is the prior content.
    task automatic scan(input logic [CH-1:0] load, output logic [CH-1:0] old, input bit do_upd);
        @(negedge test_clk);
        shift_en = 1'b1;
        for (int k = 0; k < CH; k++) begin
            scan_in = load[CH-1-k];
            #1;
            old[CH-1-k] = scan_out;
            @(negedge test_clk);
        end
        shift_en = 1'b0;
        if (do_upd) begin
            upd_en = 1'b1;
            @(negedge test_clk);
            upd_en = 1'b0;
        end
        #1;
    endtask

    task automatic t_reset();
        logic [CH-1:0] old;
        test_rst_n = 1'b0;
        mode = 2'b11;
        sys_in = 4'b0110;
        core_out = 3'b101;
        #3;
        check("R1 core_in in reset", core_in, 4'b0110);
        check("R1 sys_out in reset", sys_out, 3'b101);
        check("R1 scan_out in reset", scan_out, 0);
        @(negedge test_clk);
        test_rst_n = 1'b1;
        mode = 2'b00;
        scan('0, old, 1'b0);
        check("R1 cleared chain", old, 0);
    endtask

    task automatic t_normal();
        mode = 2'b00;
        sys_in = 4'b1100;
        core_out = 3'b010;
        #1;
        check("R2 core_in pass A", core_in, 4'b1100);
        check("R2 sys_out pass A", sys_out, 3'b010);
        sys_in = 4'b0011;
        core_out = 3'b111;
        #1;
        check("R2 core_in pass B", core_in, 4'b0011);
        check("R2 sys_out pass B", sys_out, 3'b111);
    endtask

    task automatic t_inward_outward();
        logic [CH-1:0] old;
        logic [CH-1:0] pat = 7'b1011001;
        scan(pat, old, 1'b1);
        mode = 2'b01;
        sys_in = 4'b0000;
        core_out = 3'b100;
        #1;
        check("R3 core_in from update", core_in, pat[NI-1:0]);
        check("R3 sys_out passes", sys_out, 3'b100);
        mode = 2'b10;
        #1;
        check("R4 sys_out from update", sys_out, pat[CH-1:NI]);
        check("R4 core_in passes", core_in, 4'b0000);
        mode = 2'b00;
        scan(7'b0, old, 1'b0);
        check("R6 scan-out order", old, pat);
    endtask

    task automatic t_safe();
        mode = 2'b11;
        sys_in = 4'b0101;
        core_out = 3'b100;
        #1;
        check("R5 core_in safe", core_in, S_IN);
        check("R5 sys_out safe", sys_out, S_OUT);
    endtask

    task automatic t_capture();
        logic [CH-1:0] old;
        mode = 2'b01;
        sys_in = 4'b1001;
        core_out = 3'b110;
        @(negedge test_clk);
        cap_en = 1'b1;
        shift_en = 1'b1;
        scan_in = 1'b1;
        @(negedge test_clk);
        cap_en = 1'b0;
        shift_en = 1'b0;
        scan('0, old, 1'b0);
        check("R7 capture over shift", old, {3'b110, 4'b1001});
        mode = 2'b00;
    endtask

    task automatic t_update_hold();
        logic [CH-1:0] old;
        logic [CH-1:0] a = 7'b0100110;
        logic [CH-1:0] b = 7'b1011001;
        scan(a, old, 1'b1);
        mode = 2'b01;
        scan(b, old, 1'b0);
        check("R8 core_in held after shift", core_in, a[NI-1:0]);
        mode = 2'b10;
        #1;
        check("R8 sys_out held after shift", sys_out, a[CH-1:NI]);
        @(negedge test_clk);
        upd_en = 1'b1;
        @(negedge test_clk);
        upd_en = 1'b0;
        #1;
        check("R8 sys_out after update", sys_out, b[CH-1:NI]);
        mode = 2'b00;
    endtask

    task automatic t_safe_shift();
        logic [CH-1:0] old;
        logic [CH-1:0] c = 7'b0110101;
        mode = 2'b11;
        scan(c, old, 1'b1);
        check("R9 still safe after update", core_in, S_IN);
        mode = 2'b01;
        #1;
        check("R9 pattern from safe mode", core_in, c[NI-1:0]);
        mode = 2'b00;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_inward_outward();
        t_safe();
        t_capture();
        t_update_hold();
        t_safe_shift();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule